// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Controller Pair

This block joins two eight-input priority interrupt controllers into one sixteen-input interrupt system. One controller acts as the master and the other as the slave. Each controller keeps its own request, in-service, mask and trigger-mode registers, its own vector base and its own priority rotation. The slave's request is fed into master input 2. The master's request output is the system interrupt line `intr`.

Software reaches both controllers through a byte-wide register port. A request on that port uses a valid/ready handshake. `bus_ready` is low only in a cycle in which `inta` is high, and a request presented in such a cycle stays pending until a later cycle accepts it. An accepted read returns `rsp_valid` with `rsp_data` on the next clock. The read response has no back-pressure. When the processor pulses `inta`, the pair runs the acknowledge through the master and, if the master picks input 2, through the slave as well. It then presents an 8-bit vector with a one-cycle `vec_valid`.

Top module: `pic_cascade_pair`

## Requirements
- R1: Request line n is routed to controller n/8 (0 = master, 1 = slave) on input n mod 8. A request on a master line raises `intr` on the clock edge that latches it.
- R2: A line whose trigger-mode bit is 0 latches a request on its rising edge, and the request persists after the line falls. A line whose bit is 1 follows the line's level. Only trigger-mode bits 3..7 of the master and bits 1..4, 6, 7 of the slave (masks 0xF8 and 0xDE) can be set. All other bits read back as 0.
- R3: While the slave has a pending request, master request bit 2 is set on every clock edge. A rising slave line therefore raises `intr` two clock edges after it is applied.
- R4: When `inta` is high and the master's best line is not 2, the vector is {master base[7:3], line}. `vec_valid` is high for exactly the one cycle after the `inta` cycle.
- R5: When the master's best line is 2, the slave is acknowledged as well. The vector is {slave base[7:3], slave line}, and in-service bit 2 of the master and the slave's line bit are both set.
- R6: If the master has nothing to deliver at acknowledge, the vector is master base + 7. If the master picks line 2 but the slave has nothing to deliver, the vector is slave base + 7.
- R7: The lowest line number has the highest priority. A set-priority command (command byte 110_xxx_lll) makes line lll+1 the highest priority. A non-specific end-of-interrupt (0x20) clears the highest-priority in-service bit.
- R8: A set mask bit stops its line from raising `intr`, but its request bit is still latched. Clearing the mask bit lets the request through.
- R9: Address bit 7 selects the controller. Address 0x20/0xA0 is the command port and 0x21/0xA1 is the data port. The trigger-mode registers are at 0xD0 (master) and 0xD1 (slave). Writes to any other address have no effect, and reads of any other address return 0.
- R10: A command read after a poll command (0x0C) returns 0x80 + the best line and clears that line's request. A slave poll also clears master request and in-service bit 2. If no line is pending, the poll read returns 0x07.
- R11: An access with `bus_size` not 0 (wider than a byte) changes no state. If it is a read, it returns data 0.
- R12: After reset `intr` is low, all mask and trigger-mode bits are 0, and the master waits for initialization. Its first data-port write sets the vector base and its second completes the setup. Later data writes set the mask.
- R13: `bus_ready` is low while `inta` is high, and no read response comes from that cycle. An accepted read gives `rsp_valid` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines | input | 16 | Request lines; bits 0-7 master, 8-15 slave |
| bus_valid | input | 1 | Register access request |
| bus_ready | output | 1 | Access accepted this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access width code; 0 = single byte |
| bus_addr | input | 8 | Port address |
| bus_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 8 | Read data |
| intr | output | 1 | Interrupt request to the processor |
| inta | input | 1 | Interrupt acknowledge strobe |
| vec_valid | output | 1 | Vector valid, one cycle |
| vec_data | output | 8 | Interrupt vector |

## Verification
Each result has a fixed delay, and the bench samples one time unit after the rising clock edge on which the result is due:

| Result | When it is due |
|---|---|
| Master request line change | Registered on the first edge; `intr` follows combinationally in that same cycle. |
| Slave request | Two edges: the slave latches it, then master bit 2 latches it. The bench checks `intr` after each of those edges. |
| Vector and read data | Registered on the edge that ends the `inta` or access cycle. |
| Register write | Visible from the edge that ends the access cycle; the first read issued afterwards checks it. |
| `bus_ready` | Combinational; checked before the edge while `inta` is held. |

// File: rtl/pic_pair_pkg.sv
package pic_pair_pkg;
  localparam int LINES   = 8;
  localparam int LINE_W  = $clog2(LINES);

  typedef enum logic [1:0] {RSEL_NONE, RSEL_CMD, RSEL_DAT, RSEL_MODE} rsel_e;
  typedef enum logic [1:0] {ST_RUN, ST_BASE, ST_CASC, ST_OPTS} init_e;

  typedef struct packed {
    logic              found;
    logic [LINE_W-1:0] rank;
  } scan_t;

  // rank 0 is the highest priority; line = rank + rotation
  function automatic scan_t scan_prio(input logic [LINES-1:0] bits,
                                      input logic [LINE_W-1:0] rot);
    scan_t r;
    r.found = 1'b0;
    r.rank  = '0;
    for (int k = LINES-1; k >= 0; k--) begin
      logic [LINE_W-1:0] idx;
      idx = LINE_W'(k) + rot;
      if (bits[idx]) begin
        r.found = 1'b1;
        r.rank  = LINE_W'(k);
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/pic_unit.sv
module pic_unit
  import pic_pair_pkg::*;
#(
  parameter logic [LINES-1:0] MODE_MASK = 8'hF8,
  parameter bit               RST_AWAIT = 1'b0,
  parameter int               CASC_PIN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  lines,
  input  logic              cas_set,
  input  logic              cas_clr,
  input  logic              wr_cmd,
  input  logic              wr_dat,
  input  logic              rd_cmd,
  input  logic              wr_mode,
  input  logic [7:0]        wdata,
  input  logic              ack,
  output logic              int_req,
  output logic [LINE_W-1:0] best_line,
  output logic [4:0]        base,
  output logic              poll_take,
  output logic [7:0]        cmd_rdata,
  output logic [LINES-1:0]  mask_q,
  output logic [LINES-1:0]  mode_q
);
  logic [LINES-1:0] irr_q, isr_q, last_q, irr_n, isr_n;
  logic [LINE_W-1:0] rot_q, isr_top;
  logic [4:0] base_q;
  init_e step_q;
  logic need_opts_q, aeoi_q, rot_aeoi_q, rd_isr_q, poll_q;
  scan_t pend_s, isr_s;
  logic icw1, ocw2, ocw3, ack_hit, eoi_ns, eoi_sp;
  logic [2:0] op;

  always_comb begin
    pend_s    = scan_prio(irr_q & ~mask_q, rot_q);
    isr_s     = scan_prio(isr_q, rot_q);
    int_req   = pend_s.found && (!isr_s.found || (pend_s.rank < isr_s.rank));
    best_line = pend_s.rank + rot_q;
    isr_top   = isr_s.rank + rot_q;
  end

  assign op        = wdata[7:5];
  assign icw1      = wr_cmd && wdata[4];
  assign ocw3      = wr_cmd && !wdata[4] && wdata[3];
  assign ocw2      = wr_cmd && !wdata[4] && !wdata[3];
  assign ack_hit   = ack && int_req;
  assign poll_take = rd_cmd && poll_q && int_req;
  assign eoi_ns    = ocw2 && ((op == 3'd1) || (op == 3'd5)) && isr_s.found;
  assign eoi_sp    = ocw2 && ((op == 3'd3) || (op == 3'd7));
  assign base      = base_q;

  always_comb begin
    irr_n = irr_q;
    for (int b = 0; b < LINES; b++) begin
      if (mode_q[b])                   irr_n[b] = lines[b];
      else if (lines[b] && !last_q[b]) irr_n[b] = 1'b1;
    end
    if (cas_set) irr_n[CASC_PIN] = 1'b1;
    if (ack_hit && !mode_q[best_line]) irr_n[best_line] = 1'b0;
    if (poll_take) irr_n[best_line] = 1'b0;
    if (cas_clr) irr_n[CASC_PIN] = 1'b0;
    if (icw1) irr_n = '0;
  end

  always_comb begin
    isr_n = isr_q;
    if (ack_hit && !aeoi_q) isr_n[best_line] = 1'b1;
    if (eoi_ns) isr_n[isr_top] = 1'b0;
    if (eoi_sp) isr_n[wdata[LINE_W-1:0]] = 1'b0;
    if (poll_take) isr_n[best_line] = 1'b0;
    if (cas_clr) isr_n[CASC_PIN] = 1'b0;
    if (icw1) isr_n = '0;
  end

  always_comb begin
    if (poll_q)        cmd_rdata = int_req ? {1'b1, 4'b0000, best_line} : 8'h07;
    else if (rd_isr_q) cmd_rdata = isr_q;
    else               cmd_rdata = irr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q <= '0; isr_q <= '0; last_q <= '0; mask_q <= '0; mode_q <= '0;
      rot_q <= '0; base_q <= '0; need_opts_q <= 1'b0; aeoi_q <= 1'b0;
      rot_aeoi_q <= 1'b0; rd_isr_q <= 1'b0; poll_q <= 1'b0;
      step_q <= RST_AWAIT ? ST_BASE : ST_RUN;
    end else begin
      irr_q  <= irr_n;
      isr_q  <= isr_n;
      last_q <= icw1 ? '0 : lines;
      if (rd_cmd) poll_q <= 1'b0;
      if (wr_mode) mode_q <= wdata & MODE_MASK;
      if (icw1) begin
        mask_q <= '0; rot_q <= '0; base_q <= '0; step_q <= ST_BASE;
        need_opts_q <= wdata[0]; aeoi_q <= 1'b0; rot_aeoi_q <= 1'b0;
        rd_isr_q <= 1'b0; poll_q <= 1'b0;
      end else if (ocw3) begin
        if (wdata[2]) poll_q <= 1'b1;
        if (wdata[1]) rd_isr_q <= wdata[0];
      end else if (ocw2) begin
        case (op)
          3'd0, 3'd4: rot_aeoi_q <= op[2];
          3'd5:       if (isr_s.found) rot_q <= isr_top + 3'd1;
          3'd6, 3'd7: rot_q <= wdata[LINE_W-1:0] + 3'd1;
          default:    ;
        endcase
      end
      if (wr_dat) begin
        case (step_q)
          ST_RUN:  mask_q <= wdata;
          ST_BASE: begin base_q <= wdata[7:3]; step_q <= ST_CASC; end
          ST_CASC: step_q <= need_opts_q ? ST_OPTS : ST_RUN;
          default: begin aeoi_q <= wdata[1]; step_q <= ST_RUN; end
        endcase
      end
      if (ack_hit && aeoi_q && rot_aeoi_q) rot_q <= best_line + 3'd1;
    end
  end

  // R3: a cascade pulse leaves request bit 2 set unless a clear competes
  p_casc_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_set && !icw1 && !cas_clr && !poll_take && !ack) |=> irr_q[CASC_PIN]);

  // R10: the polled line's request is gone after the poll read
  p_poll_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    poll_take |=> !irr_q[$past(best_line)]);

  // R2: a level-mode line that is low leaves no request behind
  for (genvar b = 0; b < LINES; b++) begin : g_lvl
    p_level_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[b] && !lines[b] && !(cas_set && (b == CASC_PIN))) |=> !irr_q[b]);
  end
endmodule

// File: rtl/pic_port_decode.sv
module pic_port_decode
  import pic_pair_pkg::*;
#(
  parameter int              AW       = 8,
  parameter int              NCTL     = 2,
  parameter int              SZW      = 2,
  parameter logic [AW-3:0]   CTL_PAT  = 6'h10,
  parameter logic [AW-2:0]   MODE_PAT = 7'h68,
  localparam int             IW       = $clog2(NCTL)
) (
  input  logic            bus_valid,
  input  logic            bus_write,
  input  logic [SZW-1:0]  bus_size,
  input  logic [AW-1:0]   bus_addr,
  input  logic            inta,
  output logic            bus_ready,
  output logic            take,
  output logic [NCTL-1:0] wr_cmd,
  output logic [NCTL-1:0] wr_dat,
  output logic [NCTL-1:0] rd_cmd,
  output logic [NCTL-1:0] wr_mode,
  output rsel_e           rd_sel,
  output logic [IW-1:0]   rd_idx
);
  logic byte_ok, ctl_hit, mode_hit, a0, ok;
  logic [IW-1:0] ctl_idx, mode_idx;

  assign bus_ready = !inta;
  assign take      = bus_valid && bus_ready;
  assign byte_ok   = (bus_size == '0);
  assign ok        = take && byte_ok;
  assign ctl_hit   = (bus_addr[AW-2:1] == CTL_PAT);
  assign mode_hit  = (bus_addr[AW-1:1] == MODE_PAT);
  assign a0        = bus_addr[0];
  assign ctl_idx   = IW'(bus_addr[AW-1]);
  assign mode_idx  = IW'(bus_addr[0]);

  for (genvar i = 0; i < NCTL; i++) begin : g_strobe
    assign wr_cmd[i]  = ok && ctl_hit && bus_write && !a0 && (ctl_idx == IW'(i));
    assign wr_dat[i]  = ok && ctl_hit && bus_write &&  a0 && (ctl_idx == IW'(i));
    assign rd_cmd[i]  = ok && ctl_hit && !bus_write && !a0 && (ctl_idx == IW'(i));
    assign wr_mode[i] = ok && mode_hit && bus_write && (mode_idx == IW'(i));
  end

  always_comb begin
    rd_sel = RSEL_NONE;
    rd_idx = '0;
    if (byte_ok && ctl_hit) begin
      rd_sel = a0 ? RSEL_DAT : RSEL_CMD;
      rd_idx = ctl_idx;
    end else if (byte_ok && mode_hit) begin
      rd_sel = RSEL_MODE;
      rd_idx = mode_idx;
    end
  end
endmodule

// File: rtl/pic_vector_gen.sv
module pic_vector_gen
  import pic_pair_pkg::*;
#(
  parameter int CASC_PIN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inta,
  input  logic              m_int,
  input  logic [LINE_W-1:0] m_line,
  input  logic [4:0]        m_base,
  input  logic              s_int,
  input  logic [LINE_W-1:0] s_line,
  input  logic [4:0]        s_base,
  output logic              s_ack,
  output logic              vec_valid,
  output logic [7:0]        vec_data
);
  logic [7:0] vec_n;

  assign s_ack = inta && m_int && (m_line == LINE_W'(CASC_PIN));

  always_comb begin
    if (!m_int)                          vec_n = {m_base, 3'd7};
    else if (m_line != LINE_W'(CASC_PIN)) vec_n = {m_base, m_line};
    else if (s_int)                      vec_n = {s_base, s_line};
    else                                 vec_n = {s_base, 3'd7};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec_data  <= '0;
    end else begin
      vec_valid <= inta;
      if (inta) vec_data <= vec_n;
    end
  end

  p_vec_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    inta |=> vec_valid);
  p_vec_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(inta));
  p_spur_master_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !m_int) |=> (vec_data == {$past(m_base), 3'd7}));
  p_slave_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    s_ack |=> (vec_data[7:3] == $past(s_base)));
endmodule

// File: rtl/pic_cascade_pair.sv
module pic_cascade_pair
  import pic_pair_pkg::*;
#(
  parameter int             NCTL      = 2,
  parameter int             AW        = 8,
  parameter int             DW        = 8,
  parameter int             SZW       = 2,
  parameter int             CASC_PIN  = 2,
  parameter logic [LINES-1:0] MASK_M  = 8'hF8,
  parameter logic [LINES-1:0] MASK_S  = 8'hDE,
  localparam int            NLINES    = NCTL * LINES,
  localparam int            IW        = $clog2(NCTL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_lines,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [SZW-1:0]    bus_size,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_data,
  output logic              intr,
  input  logic              inta,
  output logic              vec_valid,
  output logic [7:0]        vec_data
);
  logic take;
  logic [NCTL-1:0] wr_cmd, wr_dat, rd_cmd, wr_mode, int_w, poll_w, ack_w, cset_w, cclr_w;
  rsel_e rd_sel;
  logic [IW-1:0] rd_idx;
  logic [LINE_W-1:0] line_w [NCTL];
  logic [4:0]        base_w [NCTL];
  logic [7:0]        cmdr_w [NCTL];
  logic [LINES-1:0]  mask_w [NCTL];
  logic [LINES-1:0]  mode_w [NCTL];
  logic s_ack;
  logic [DW-1:0] rd_mux;

  pic_port_decode #(.AW(AW), .NCTL(NCTL), .SZW(SZW)) u_dec (
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_size(bus_size),
    .bus_addr(bus_addr), .inta(inta), .bus_ready(bus_ready), .take(take),
    .wr_cmd(wr_cmd), .wr_dat(wr_dat), .rd_cmd(rd_cmd), .wr_mode(wr_mode),
    .rd_sel(rd_sel), .rd_idx(rd_idx));

  for (genvar i = 0; i < NCTL; i++) begin : g_ctl
    if (i == 0) begin : g_master
      assign ack_w[i]  = inta;
      assign cset_w[i] = int_w[1] && !inta;
      assign cclr_w[i] = poll_w[1];
    end else begin : g_slave
      assign ack_w[i]  = s_ack;
      assign cset_w[i] = 1'b0;
      assign cclr_w[i] = 1'b0;
    end
    pic_unit #(
      .MODE_MASK((i == 0) ? MASK_M : MASK_S),
      .RST_AWAIT(i == 0),
      .CASC_PIN(CASC_PIN)
    ) u_unit (
      .clk(clk), .rst_n(rst_n), .lines(irq_lines[i*LINES +: LINES]),
      .cas_set(cset_w[i]), .cas_clr(cclr_w[i]),
      .wr_cmd(wr_cmd[i]), .wr_dat(wr_dat[i]), .rd_cmd(rd_cmd[i]),
      .wr_mode(wr_mode[i]), .wdata(bus_wdata), .ack(ack_w[i]),
      .int_req(int_w[i]), .best_line(line_w[i]), .base(base_w[i]),
      .poll_take(poll_w[i]), .cmd_rdata(cmdr_w[i]), .mask_q(mask_w[i]),
      .mode_q(mode_w[i]));
  end

  pic_vector_gen #(.CASC_PIN(CASC_PIN)) u_vec (
    .clk(clk), .rst_n(rst_n), .inta(inta),
    .m_int(int_w[0]), .m_line(line_w[0]), .m_base(base_w[0]),
    .s_int(int_w[1]), .s_line(line_w[1]), .s_base(base_w[1]),
    .s_ack(s_ack), .vec_valid(vec_valid), .vec_data(vec_data));

  assign intr = int_w[0];

  always_comb begin
    case (rd_sel)
      RSEL_CMD:  rd_mux = cmdr_w[rd_idx];
      RSEL_DAT:  rd_mux = mask_w[rd_idx];
      RSEL_MODE: rd_mux = mode_w[rd_idx];
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= take && !bus_write;
      if (take && !bus_write) rsp_data <= rd_mux;
    end
  end

  p_rsp_source_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(bus_valid && !inta && !bus_write));
  p_poll_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(poll_w[0] && poll_w[1]));
endmodule

// File: tb/pic_cascade_pair_test.sv
module pic_cascade_pair_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] irq_lines = '0;
  logic bus_valid = 1'b0, bus_write = 1'b0, inta = 1'b0;
  logic [1:0] bus_size = '0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic bus_ready, rsp_valid, intr, vec_valid;
  logic [7:0] rsp_data, vec_data;
  int checks = 0, errors = 0;
  logic [7:0] rd;

  always #10 clk = ~clk;

  pic_cascade_pair uut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .bus_valid(bus_valid),
    .bus_ready(bus_ready), .bus_write(bus_write), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .intr(intr), .inta(inta), .vec_valid(vec_valid),
    .vec_data(vec_data));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic [1:0] sz = 2'd0);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
    @(posedge clk); #1;
    bus_valid = 1'b0; bus_write = 1'b0; bus_size = 2'd0;
  endtask

  task automatic rdp(input logic [7:0] a, output logic [7:0] d, input logic [1:0] sz = 2'd0);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_size = sz;
    @(posedge clk); #1;
    d = rsp_valid ? rsp_data : 8'hxx;
    bus_valid = 1'b0; bus_size = 2'd0;
  endtask

  task automatic ack_exp(input logic [7:0] exp, input string req);
    @(negedge clk); inta = 1'b1;
    @(posedge clk); #1;
    check(vec_valid === 1'b1 && vec_data === exp, req, vec_data, exp);
    inta = 1'b0;
  endtask

  task automatic line(input int n, input logic v);
    @(negedge clk); irq_lines[n] = v;
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    check(intr === 1'b0, "R12 intr after reset", intr, 0);
    rdp(8'hD0, rd); check(rd === 8'h00, "R12 master mode reset", rd, 0);
    rdp(8'hD1, rd); check(rd === 8'h00, "R12 slave mode reset", rd, 0);
    wr(8'h21, 8'h08);
    rdp(8'h21, rd); check(rd === 8'h00, "R12 first data write is base", rd, 0);
    wr(8'h21, 8'h04);
    wr(8'h21, 8'hA5);
    rdp(8'h21, rd); check(rd === 8'hA5, "R12 mask after setup", rd, 8'hA5);
    wr(8'h21, 8'h00);
    wr(8'hA0, 8'h11); wr(8'hA1, 8'h70); wr(8'hA1, 8'h02); wr(8'hA1, 8'h01);
    rdp(8'hA1, rd); check(rd === 8'h00, "R12 slave mask after setup", rd, 0);
  endtask

  task automatic t_master_ack;
    line(5, 1'b1);
    check(intr === 1'b1, "R1 line 5 raises intr", intr, 1);
    ack_exp(8'h0D, "R4 vector line 5");
    @(posedge clk); #1;
    check(vec_valid === 1'b0, "R4 vec_valid one cycle", vec_valid, 0);
    wr(8'h20, 8'h0B);
    rdp(8'h20, rd); check(rd === 8'h20, "R4 in-service line 5", rd, 8'h20);
    wr(8'h20, 8'h20);
    rdp(8'h20, rd); check(rd === 8'h00, "R7 EOI clears in-service", rd, 0);
    wr(8'h20, 8'h0A);
    line(5, 1'b0);
  endtask

  task automatic t_priority;
    @(negedge clk); irq_lines[3] = 1'b1; irq_lines[6] = 1'b1;
    @(posedge clk); #1;
    ack_exp(8'h0B, "R7 line 3 beats 6");
    wr(8'h20, 8'h20);
    ack_exp(8'h0E, "R7 line 6 next");
    wr(8'h20, 8'h20);
    @(negedge clk); irq_lines[3] = 1'b0; irq_lines[6] = 1'b0;
    wr(8'h20, 8'hC4);
    @(negedge clk); irq_lines[1] = 1'b1; irq_lines[6] = 1'b1;
    @(posedge clk); #1;
    ack_exp(8'h0E, "R7 rotated line 6 first");
    wr(8'h20, 8'h20);
    ack_exp(8'h09, "R7 rotated line 1 second");
    wr(8'h20, 8'h20);
    wr(8'h20, 8'hC7);
    @(negedge clk); irq_lines[1] = 1'b0; irq_lines[6] = 1'b0;
  endtask

  task automatic t_mask;
    wr(8'h21, 8'h02);
    line(1, 1'b1);
    check(intr === 1'b0, "R8 masked line silent", intr, 0);
    rdp(8'h20, rd); check(rd === 8'h02, "R8 masked request latched", rd, 8'h02);
    wr(8'h21, 8'h00);
    check(intr === 1'b1, "R8 unmask delivers", intr, 1);
    ack_exp(8'h09, "R8 vector after unmask");
    wr(8'h20, 8'h20);
    line(1, 1'b0);
  endtask

  task automatic t_trigger;
    line(4, 1'b1); line(4, 1'b0);
    wr(8'hD0, 8'h08);
    line(3, 1'b1);
    rdp(8'h20, rd); check(rd === 8'h18, "R2 edge kept and level seen", rd, 8'h18);
    line(3, 1'b0);
    rdp(8'h20, rd); check(rd === 8'h10, "R2 level request follows line", rd, 8'h10);
    ack_exp(8'h0C, "R2 edge request delivered");
    wr(8'h20, 8'h20);
    wr(8'hD0, 8'hFF);
    rdp(8'hD0, rd); check(rd === 8'hF8, "R2 master mode mask", rd, 8'hF8);
    wr(8'hD1, 8'hFF);
    rdp(8'hD1, rd); check(rd === 8'hDE, "R2 slave mode mask", rd, 8'hDE);
    wr(8'hD0, 8'h00); wr(8'hD1, 8'h00);
  endtask

  task automatic t_cascade;
    line(12, 1'b1);
    check(intr === 1'b0, "R3 intr low after first edge", intr, 0);
    @(posedge clk); #1;
    check(intr === 1'b1, "R3 intr after second edge", intr, 1);
    ack_exp(8'h74, "R5 slave vector line 12");
    wr(8'hA0, 8'h0B);
    rdp(8'hA0, rd); check(rd === 8'h10, "R5 slave in-service", rd, 8'h10);
    wr(8'h20, 8'h0B);
    rdp(8'h20, rd); check(rd === 8'h04, "R5 master in-service 2", rd, 8'h04);
    wr(8'hA0, 8'h20); wr(8'h20, 8'h20);
    wr(8'hA0, 8'h0A); wr(8'h20, 8'h0A);
    line(12, 1'b0);
    check(intr === 1'b0, "R5 idle after EOIs", intr, 0);
  endtask

  task automatic t_spurious;
    ack_exp(8'h0F, "R6 master spurious");
    wr(8'hD1, 8'h02);
    line(9, 1'b1);
    @(posedge clk); #1;
    line(9, 1'b0);
    check(intr === 1'b1, "R6 master bit 2 held", intr, 1);
    ack_exp(8'h77, "R6 slave spurious");
    wr(8'h20, 8'h20);
    wr(8'hD1, 8'h00);
  endtask

  task automatic t_poll;
    line(10, 1'b1);
    @(posedge clk); #1;
    wr(8'hA0, 8'h0C);
    rdp(8'hA0, rd); check(rd === 8'h82, "R10 slave poll result", rd, 8'h82);
    rdp(8'h20, rd); check(rd === 8'h00, "R10 master bit 2 cleared", rd, 0);
    check(intr === 1'b0, "R10 intr low after poll", intr, 0);
    wr(8'h20, 8'h0C);
    rdp(8'h20, rd); check(rd === 8'h07, "R10 empty poll", rd, 8'h07);
    line(10, 1'b0);
  endtask

  task automatic t_size;
    wr(8'h21, 8'h33);
    wr(8'h21, 8'hFF, 2'd1);
    rdp(8'h21, rd); check(rd === 8'h33, "R11 wide write ignored", rd, 8'h33);
    rdp(8'h21, rd, 2'd2); check(rd === 8'h00, "R11 wide read zero", rd, 0);
    wr(8'h21, 8'h00);
  endtask

  task automatic t_decode;
    wr(8'hA1, 8'h5A);
    rdp(8'hA1, rd); check(rd === 8'h5A, "R9 slave data port", rd, 8'h5A);
    rdp(8'h21, rd); check(rd === 8'h00, "R9 master data port separate", rd, 0);
    wr(8'h23, 8'hFF);
    rdp(8'h21, rd); check(rd === 8'h00, "R9 stray write ignored", rd, 0);
    rdp(8'h50, rd); check(rd === 8'h00, "R9 stray read zero", rd, 0);
    wr(8'hA1, 8'h00);
    rdp(8'h21, rd); check(rd === 8'h00, "R1 mask still clear", rd, 0);
  endtask

  task automatic t_ready;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 8'h21; inta = 1'b1;
    #1 check(bus_ready === 1'b0, "R13 ready low during inta", bus_ready, 0);
    @(posedge clk); #1;
    check(rsp_valid === 1'b0, "R13 no response when stalled", rsp_valid, 0);
    inta = 1'b0;
    #1 check(bus_ready === 1'b1, "R13 ready restored", bus_ready, 1);
    @(posedge clk); #1;
    check(rsp_valid === 1'b1, "R13 response next clock", rsp_valid, 1);
    bus_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_master_ack();
    t_priority();
    t_mask();
    t_trigger();
    t_cascade();
    t_spurious();
    t_poll();
    t_size();
    t_decode();
    t_ready();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule